// File: doc/BRIEF.md
# Condition Gate and Status Flag Register

This unit sits beside the execute stage of a 32-bit processor datapath. It holds the four user status flags (negative, zero, carry, overflow). Each cycle it decides whether the instruction being presented may take effect, using a 4-bit condition field tested against those flags. Every instruction passes through this gate, not only branches. An instruction whose condition fails becomes a no-op: its execute enable stays low, and it leaves the flags alone.

The flags change only on an instruction that executes and asks for a flag update through its set-flags bit. In that case N copies the sign bit of the ALU result, Z reports an all-zero result, and C and V copy the ALU's carry and overflow outputs. The condition test always uses the flags as they stood before the current instruction. A flag write becomes visible to the instruction in the following cycle.

Top module: `cf_exec_gate`

## Requirements
- R1: While `rst_n` is low the four flag outputs are forced to 0, and they are 0 on the first cycle after reset is released.
- R2: With `ex_valid` high, `exec_en` is high exactly when the condition holds. The encodings are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R3: Encoding 14 (always) gives `exec_en` high whenever `ex_valid` is high. Encoding 15 (never, reserved) keeps `exec_en` low.
- R4: With `ex_valid` low, `exec_en` is low and the flags keep their values.
- R5: An executing instruction with `set_flags` high loads N with bit DATA_W-1 of `alu_result`, and loads Z with 1 if `alu_result` is zero and 0 otherwise.
- R6: An executing instruction with `set_flags` high loads C from `alu_carry` and V from `alu_ovf`.
- R7: An executing instruction with `set_flags` low leaves all four flags unchanged.
- R8: An instruction whose condition fails leaves all four flags unchanged, even with `set_flags` high.
- R9: `exec_en` is evaluated against the flags held before the current instruction. A flag write shows on the flag outputs, and in the condition test, from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction is presented this cycle |
| cond | input | 4 | Condition field of the instruction |
| set_flags | input | 1 | Instruction requests a flag update |
| alu_result | input | DATA_W | ALU result for this instruction |
| alu_carry | input | 1 | ALU carry output |
| alu_ovf | input | 1 | ALU signed overflow output |
| exec_en | output | 1 | Instruction may take effect |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Two functions share a cycle: the condition test for an instruction, and the flag write that the same instruction may cause. The bench sets a flag state. It then issues a flag-setting instruction whose condition depends on that state and whose result would invert it. It checks that `exec_en` follows the old flags during the instruction and that the new flags appear only after the edge. A back-to-back pair then confirms that the second instruction is judged on the flags written by the first.

// File: rtl/cf_pkg.sv
package cf_pkg;

    typedef enum logic [3:0] {
        COND_EQ = 4'd0,
        COND_NE = 4'd1,
        COND_CS = 4'd2,
        COND_CC = 4'd3,
        COND_MI = 4'd4,
        COND_PL = 4'd5,
        COND_VS = 4'd6,
        COND_VC = 4'd7,
        COND_HI = 4'd8,
        COND_LS = 4'd9,
        COND_GE = 4'd10,
        COND_LT = 4'd11,
        COND_GT = 4'd12,
        COND_LE = 4'd13,
        COND_AL = 4'd14,
        COND_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/cf_cond_eval.sv
module cf_cond_eval
    import cf_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);

    cond_e  code;
    logic   sign_match;

    assign code       = cond_e'(cond_i);
    assign sign_match = (flags_i.n == flags_i.v);

    always_comb begin
        pass_o = 1'b0;
        unique case (code)
            COND_EQ: pass_o = flags_i.z;
            COND_NE: pass_o = !flags_i.z;
            COND_CS: pass_o = flags_i.c;
            COND_CC: pass_o = !flags_i.c;
            COND_MI: pass_o = flags_i.n;
            COND_PL: pass_o = !flags_i.n;
            COND_VS: pass_o = flags_i.v;
            COND_VC: pass_o = !flags_i.v;
            COND_HI: pass_o = flags_i.c && !flags_i.z;
            COND_LS: pass_o = !flags_i.c || flags_i.z;
            COND_GE: pass_o = sign_match;
            COND_LT: pass_o = !sign_match;
            COND_GT: pass_o = !flags_i.z && sign_match;
            COND_LE: pass_o = flags_i.z || !sign_match;
            COND_AL: pass_o = 1'b1;
            COND_NV: pass_o = 1'b0;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cf_flag_next.sv
module cf_flag_next
    import cf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output flags_t            next_o
);

    localparam int MSB = DATA_W - 1;

    logic is_zero;

    generate
        if (DATA_W > 1) begin : g_wide
            assign is_zero = ~|result_i;
        end else begin : g_single
            assign is_zero = ~result_i[0];
        end
    endgenerate

    always_comb begin
        next_o.n = result_i[MSB];
        next_o.z = is_zero;
        next_o.c = carry_i;
        next_o.v = ovf_i;
    end

endmodule

// File: rtl/cf_flag_reg.sv
module cf_flag_reg
    import cf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we_i,
    input  flags_t d_i,
    output flags_t q_o
);

    flags_t state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAGS_RESET;
        end else if (we_i) begin
            state_q <= d_i;
        end
    end

    assign q_o = state_q;

endmodule

// File: rtl/cf_exec_gate.sv
module cf_exec_gate
    import cf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic [3:0]        cond,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    output logic              exec_en,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    flags_t cur_flags;
    flags_t new_flags;
    logic   cond_pass;
    logic   flag_we;

    cf_cond_eval u_eval (
        .cond_i  (cond),
        .flags_i (cur_flags),
        .pass_o  (cond_pass)
    );

    cf_flag_next #(.DATA_W(DATA_W)) u_next (
        .result_i (alu_result),
        .carry_i  (alu_carry),
        .ovf_i    (alu_ovf),
        .next_o   (new_flags)
    );

    assign flag_we = ex_valid && cond_pass && set_flags;

    cf_flag_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (flag_we),
        .d_i   (new_flags),
        .q_o   (cur_flags)
    );

    assign exec_en = ex_valid && cond_pass;
    assign flag_n  = cur_flags.n;
    assign flag_z  = cur_flags.z;
    assign flag_c  = cur_flags.c;
    assign flag_v  = cur_flags.v;

endmodule

// File: rtl/cf_exec_gate_chk.sv
module cf_exec_gate_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_valid,
    input logic [3:0]        cond,
    input logic              set_flags,
    input logic [DATA_W-1:0] alu_result,
    input logic              alu_carry,
    input logic              alu_ovf,
    input logic              exec_en,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    logic [3:0] flags;
    assign flags = {flag_n, flag_z, flag_c, flag_v};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == 4'b0000));

    assert_always_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && cond == 4'd14) |-> exec_en);

    assert_never_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd15) |-> !exec_en);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !exec_en);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> $stable(flags));

    assert_nz_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && set_flags) |=>
            (flag_n == $past(alu_result[DATA_W-1]) && flag_z == ($past(alu_result) == '0)));

    assert_cv_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && set_flags) |=>
            (flag_c == $past(alu_carry) && flag_v == $past(alu_ovf)));

    assert_no_s_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !set_flags) |=> $stable(flags));

    assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !exec_en) |=> $stable(flags));

endmodule

bind cf_exec_gate cf_exec_gate_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_valid   (ex_valid),
    .cond       (cond),
    .set_flags  (set_flags),
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .alu_ovf    (alu_ovf),
    .exec_en    (exec_en),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .flag_v     (flag_v)
);

// File: tb/cf_exec_gate_bench.sv
`timescale 1ns/1ps
module cf_exec_gate_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ex_valid = 1'b0;
    logic [3:0]   cond = 4'd14;
    logic         set_flags = 1'b0;
    logic [W-1:0] alu_result = '0;
    logic         alu_carry = 1'b0;
    logic         alu_ovf = 1'b0;
    logic         exec_en, flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model;
    bit finished = 0;

    always #5 clk = ~clk;

    cf_exec_gate #(.DATA_W(W)) u_cf_exec_gate (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .cond(cond),
        .set_flags(set_flags), .alu_result(alu_result), .alu_carry(alu_carry),
        .alu_ovf(alu_ovf), .exec_en(exec_en), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One instruction: drive at negedge, judge exec_en before the edge, flags after it.
    task automatic step(input bit v, input logic [3:0] c, input bit s,
                        input logic [W-1:0] r, input bit cy, input bit ov, input string req);
        bit en_exp;
        @(negedge clk);
        ex_valid = v; cond = c; set_flags = s; alu_result = r; alu_carry = cy; alu_ovf = ov;
        #1;
        en_exp = v && exp_pass(c, model);
        check(exec_en == en_exp, {req, " exec_en"}, exec_en, en_exp);
        if (en_exp && s) model = {r[W-1], (r == '0), cy, ov};
        @(posedge clk);
        #1;
        check({flag_n, flag_z, flag_c, flag_v} == model, {req, " flags"},
              {flag_n, flag_z, flag_c, flag_v}, model);
    endtask

    task automatic set_state(input logic [3:0] f);
        logic [W-1:0] r;
        r = f[2] ? '0 : (f[3] ? 8'h80 : 8'h01);
        step(1'b1, 4'd14, 1'b1, r, f[1], f[0], "R3 setup");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        check({flag_n, flag_z, flag_c, flag_v} == 4'b0000, "R1 in reset",
              {flag_n, flag_z, flag_c, flag_v}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check({flag_n, flag_z, flag_c, flag_v} == 4'b0000, "R1 after release",
              {flag_n, flag_z, flag_c, flag_v}, 0);

        // R2/R8 sweep: every reachable flag state against every condition,
        // each probe trying to invert the flags.
        for (int st = 0; st < 16; st++) begin
            if (st[3] && st[2]) continue;
            for (int cc = 0; cc < 16; cc++) begin
                logic [W-1:0] r;
                set_state(st[3:0]);
                r = st[2] ? 8'h80 : 8'h00;
                step(1'b1, cc[3:0], 1'b1, r, !st[1], !st[0], "R2 R8 sweep");
            end
        end

        // R4: no valid, no effect
        set_state(4'b0010);
        for (int cc = 0; cc < 16; cc++)
            step(1'b0, cc[3:0], 1'b1, 8'h00, 1'b0, 1'b1, "R4 idle");

        // R5: every result value
        for (int rv = 0; rv < 256; rv++)
            step(1'b1, 4'd14, 1'b1, rv[7:0], rv[0], rv[1], "R5 nz");

        // R6: carry and overflow combinations
        for (int k = 0; k < 4; k++)
            step(1'b1, 4'd14, 1'b1, 8'h11, k[1], k[0], "R6 cv");

        // R7: set_flags low
        set_state(4'b1011);
        for (int k = 0; k < 8; k++)
            step(1'b1, 4'd14, 1'b0, 8'(k), 1'b0, 1'b0, "R7 no-s");

        // R9: condition uses old flags; write seen next cycle
        set_state(4'b0100);
        step(1'b1, 4'd0, 1'b1, 8'h05, 1'b0, 1'b0, "R9 old flags");
        step(1'b1, 4'd0, 1'b1, 8'h00, 1'b1, 1'b1, "R9 new flags");
        step(1'b1, 4'd1, 1'b1, 8'h00, 1'b1, 1'b1, "R9 back-to-back");
        check(flag_z == 1'b1, "R9 z kept", flag_z, 1);

        @(negedge clk);
        ex_valid = 1'b0;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule